// File: doc/BRIEF.md
# Serial Relay Configuration Loader

This block lives in a timing controller and sets up the signal-routing relays on as many as eight filter cards. The cards share one serial backplane bus. The block holds one 16-bit relay word per card and one 16-bit control word. Software writes the relay words first. It then sets one or more per-card start flags in the control word. For each flagged card the block puts the card number on the address lines and pulls the active-low select down. It shifts the relay word out on a divided serial clock, most significant bit first. It then raises select, and the card applies the new relay state on that edge. When that card's transfer ends, the block clears the card's start flag, so the flag also serves as a done indicator.

Two further control bits drive the diagnostic test signal, which is derived from an RF-phase input. One bit enables it. The other picks its form: either the RF waveform passes through continuously, or exactly seven RF pulses are passed after each turn event. A third control bit holds the cards' shared reset line low.

Top module: `relay_cfg_loader`

## Requirements
- R1: After reset, select is high, the serial clock is low, the control word is 0, the card reset line is high and the diagnostic output is low.
- R2: While select is low, the address lines hold the index of the card being loaded and do not change.
- R3: Each select-low window carries exactly 16 serial clock rising edges. Data is taken on those edges, most significant bit first. Data changes only while the serial clock is low.
- R4: A card's start flag (control bit k for card k) reads 1 while its word is shifted. It is cleared on the same clock edge on which select rises after the 16th bit.
- R5: When several start flags are set, the cards are loaded one at a time, lowest card index first.
- R6: Between two transfers, select stays high for at least one full serial clock period (2*DIV system clocks).
- R7: Channel n (1..8) uses bits 2n-1:2n-2 of the relay word: the input relay in the lower bit and the test-signal relay in the upper bit, with 1 energising the relay. The codes are 00 sensor to digitizer, 01 test signal to sensor, 10 test signal to sensor and digitizer, 11 test signal to digitizer. These fields reach the card unchanged.
- R8: With control bit 9 at 0, the diagnostic output stays low whatever the RF phase and turn inputs do.
- R9: With bit 9 at 1 and bit 10 at 0, the diagnostic output follows the RF phase input one clock later.
- R10: With bits 9 and 10 both at 1, each turn event yields exactly seven diagnostic pulses, one for each of the next seven RF high phases. Without a turn event no pulse appears.
- R11: Control bit 15 set to 1 drives the card reset line low; cleared to 0, the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | 0..7 relay word of that card, 8 control word |
| wr_data | input | 16 | Write data |
| ctrl_q | output | 16 | Current control word, start flags included |
| rf_ph | input | 1 | RF phase, sampled in the clk domain |
| turn_evt | input | 1 | One-cycle turn event pulse |
| bus_addr | output | 3 | Card address |
| bus_cs_n | output | 1 | Active-low card select |
| bus_sclk | output | 1 | Serial clock |
| bus_sdo | output | 1 | Serial data to the cards |
| bus_rst_n | output | 1 | Active-low card reset |
| diag_out | output | 1 | Gated diagnostic test signal |

## Verification
Four bus timing properties are checked on every cycle: the serial clock is idle low while select is high, the address is stable while select is low, data is stable while the serial clock is high, and select stays high for at least one cycle after it rises. Other behaviour is visible only across a whole frame or a sequence of frames, so the bench scenarios cover it. This covers the count and order of the bits, the word each card receives, the ascending service order, the gap length, the done flag clearing, the seven-pulse burst count and the test-signal and reset gating.

// File: rtl/relay_cfg_loader.sv
module relay_cfg_loader #(
  parameter int CARDS = 8,
  parameter int WIDTH = 16,
  parameter int DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] ctrl_q,
  input  logic        rf_ph,
  input  logic        turn_evt,
  output logic [2:0]  bus_addr,
  output logic        bus_cs_n,
  output logic        bus_sclk,
  output logic        bus_sdo,
  output logic        bus_rst_n,
  output logic        diag_out
);
  localparam int AW = $clog2(CARDS);
  localparam int BW = $clog2(WIDTH);
  localparam int TW = $clog2(2 * DIV) + 1;
  localparam logic [3:0] CTRL_ADDR = 4'(CARDS);

  typedef enum logic [1:0] {IDLE, SHIFT, GAP} st_t;

  st_t              st;
  logic [15:0]      ctrl, ctrl_nxt;
  logic [WIDTH-1:0] card_data [CARDS];
  logic [WIDTH-1:0] sh;
  logic [BW-1:0]    bitc;
  logic [TW-1:0]    tmr;
  logic [AW-1:0]    cur, pick;
  logic             pend, last_fall;

  always_comb begin
    pend = 1'b0;
    pick = '0;
    for (int i = CARDS - 1; i >= 0; i--)
      if (ctrl[i]) begin
        pend = 1'b1;
        pick = AW'(i);
      end
  end

  assign last_fall = (st == SHIFT) && (tmr == TW'(DIV - 1)) && bus_sclk && (bitc == BW'(WIDTH - 1));

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_en && wr_addr == CTRL_ADDR) ctrl_nxt = wr_data;
    if (last_fall) ctrl_nxt[cur] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < CARDS; i++) card_data[i] <= '0;
    end else if (wr_en && wr_addr < CTRL_ADDR) begin
      card_data[wr_addr[AW-1:0]] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; bus_cs_n <= 1'b1; bus_sclk <= 1'b0;
      sh <= '0; bitc <= '0; tmr <= '0; cur <= '0;
    end else begin
      case (st)
        IDLE: if (pend) begin
          bus_cs_n <= 1'b0; cur <= pick; sh <= card_data[pick];
          bitc <= '0; tmr <= '0; bus_sclk <= 1'b0; st <= SHIFT;
        end
        SHIFT: if (tmr == TW'(DIV - 1)) begin
          tmr <= '0;
          if (!bus_sclk) bus_sclk <= 1'b1;
          else begin
            bus_sclk <= 1'b0;
            if (bitc == BW'(WIDTH - 1)) begin
              bus_cs_n <= 1'b1; st <= GAP;
            end else begin
              sh <= sh << 1; bitc <= bitc + 1'b1;
            end
          end
        end else tmr <= tmr + 1'b1;
        GAP: if (tmr == TW'(2 * DIV - 1)) begin
          tmr <= '0; st <= IDLE;
        end else tmr <= tmr + 1'b1;
        default: st <= IDLE;
      endcase
    end

  assign bus_addr  = 3'(cur);
  assign bus_sdo   = sh[WIDTH-1];
  assign bus_rst_n = ~ctrl[15];
  assign ctrl_q    = ctrl;

  logic       rf_q, active, rise;
  logic [2:0] left;
  assign rise = rf_ph & ~rf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rf_q <= 1'b0; active <= 1'b0; left <= '0; diag_out <= 1'b0;
    end else begin
      rf_q <= rf_ph;
      if (!rf_ph) active <= 1'b0;
      else if (rise && left != 0) active <= 1'b1;
      if (rise && left != 0) left <= left - 1'b1;
      else if (turn_evt && left == 0) left <= 3'd7;
      diag_out <= ctrl[9] & rf_ph & (~ctrl[10] | active | (rise & (left != 0)));
    end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> !bus_sclk);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));
  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sclk |-> $stable(bus_sdo));
  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |=> bus_cs_n);
endmodule

// File: tb/relay_cfg_loader_test.sv
module relay_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, rf_ph = 0, turn_evt = 0;
  logic [3:0] wr_addr = 0;
  logic [15:0] wr_data = 0, ctrl_q;
  logic [2:0] bus_addr;
  logic bus_cs_n, bus_sclk, bus_sdo, bus_rst_n, diag_out;
  int total = 0, bad = 0, cyc = 0;
  logic [18:0] expq[$];
  logic rf_run = 0;

  relay_cfg_loader #(.CARDS(8), .WIDTH(16), .DIV(DIV)) uut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ctrl_q, .rf_ph, .turn_evt,
    .bus_addr, .bus_cs_n, .bus_sclk, .bus_sdo, .bus_rst_n, .diag_out);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic load_and_go(input logic [15:0] words [8], input logic [7:0] mask, input logic [15:0] mode);
    for (int k = 0; k < 8; k++)
      if (mask[k]) begin
        wr(4'(k), words[k]);
        expq.push_back({3'(k), words[k]});
      end
    wr(4'd8, mode | {8'd0, mask});
    for (int t = 0; t < 3000 && ctrl_q[7:0] != 0; t++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  logic pcs = 1, psclk = 0, psdo = 0, started = 0;
  logic [2:0] faddr;
  logic [15:0] word;
  int nbits, end_cyc;
  always @(negedge clk) if (rst_n) begin
    if (pcs && !bus_cs_n) begin
      if (started) chk(cyc - end_cyc >= 2*DIV, "R6 gap", cyc - end_cyc, 2*DIV);
      chk(ctrl_q[bus_addr] == 1, "R4 flag set during load", ctrl_q[bus_addr], 1);
      faddr = bus_addr; word = 0; nbits = 0; started = 1;
    end
    if (!bus_cs_n) begin
      if (!psclk && bus_sclk) begin word = {word[14:0], bus_sdo}; nbits++; end
      if (psclk && bus_sclk && bus_sdo != psdo) chk(0, "R3 data moved while clock high", bus_sdo, psdo);
      if (bus_addr != faddr) chk(0, "R2 address moved", bus_addr, faddr);
    end
    if (!pcs && bus_cs_n) begin
      logic [18:0] e;
      end_cyc = cyc;
      chk(nbits == 16, "R3 bit count", nbits, 16);
      chk(ctrl_q[faddr] == 0, "R4 flag cleared at select rise", ctrl_q[faddr], 0);
      if (expq.size() == 0) chk(0, "R5 unexpected frame", faddr, 0);
      else begin
        e = expq.pop_front();
        chk(faddr == e[18:16], "R5 card order", faddr, e[18:16]);
        chk(word == e[15:0], "R3 R7 word", word, e[15:0]);
      end
    end
    pcs = bus_cs_n; psclk = bus_sclk; psdo = bus_sdo;
  end

  initial forever begin
    @(posedge clk); #2;
    if (rf_run && (cyc % 3 == 0)) rf_ph = ~rf_ph;
  end

  int drise = 0, rrise = 0;
  logic pd = 0, pr = 0;
  always @(negedge clk) begin
    if (diag_out && !pd) drise++;
    if (rf_ph && !pr) rrise++;
    pd = diag_out; pr = rf_ph;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w [8];
    logic [1:0] codes [8];
    int d0, r0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n == 1 && bus_sclk == 0, "R1 bus idle", {bus_cs_n, bus_sclk}, 2'b10);
    chk(ctrl_q == 0 && bus_rst_n == 1 && diag_out == 0, "R1 regs", ctrl_q, 0);
    rst_n = 1;

    // R7: channel codes packed into their fields
    codes = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b10};
    for (int k = 0; k < 8; k++) w[k] = 0;
    for (int n = 1; n <= 8; n++) w[2][2*n-1 -: 2] = codes[n-1];
    load_and_go(w, 8'b0000_0100, 16'h0);
    chk(ctrl_q[7:0] == 0, "R4 all done", ctrl_q[7:0], 0);

    // R5: several cards, ascending
    w = '{16'hA5C3, 16'h8001, 16'h0000, 16'hFFFF, 16'h1234, 16'h7E7E, 16'hC0DE, 16'h5AA5};
    load_and_go(w, 8'b1011_0101, 16'h0);
    load_and_go(w, 8'b1111_1111, 16'h0);
    chk(expq.size() == 0, "R5 all frames seen", expq.size(), 0);

    // R11
    wr(4'd8, 16'h8000); @(negedge clk);
    chk(bus_rst_n == 0, "R11 reset low", bus_rst_n, 0);
    wr(4'd8, 16'h0000); @(negedge clk);
    chk(bus_rst_n == 1, "R11 reset released", bus_rst_n, 1);

    rf_run = 1;
    // R8
    d0 = drise; @(posedge clk); #1 turn_evt = 1; @(posedge clk); #1 turn_evt = 0;
    repeat (100) @(posedge clk); @(negedge clk);
    chk(drise == d0, "R8 disabled", drise - d0, 0);
    // R9
    wr(4'd8, 16'h0200); repeat (5) @(posedge clk); @(negedge clk);
    d0 = drise; r0 = rrise;
    repeat (120) @(posedge clk); @(negedge clk);
    chk((drise - d0) - (rrise - r0) <= 1 && (rrise - r0) - (drise - d0) <= 1 && rrise > r0,
        "R9 continuous", drise - d0, rrise - r0);
    // R10
    wr(4'd8, 16'h0600); repeat (20) @(posedge clk); @(negedge clk);
    d0 = drise; repeat (80) @(posedge clk); @(negedge clk);
    chk(drise == d0, "R10 no turn no pulse", drise - d0, 0);
    for (int b = 0; b < 2; b++) begin
      d0 = drise;
      @(posedge clk); #1 turn_evt = 1; @(posedge clk); #1 turn_evt = 0;
      repeat (120) @(posedge clk); @(negedge clk);
      chk(drise - d0 == 7, "R10 burst count", drise - d0, 7);
    end
    rf_run = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule